// File: doc/BRIEF.md
# Delay Memory Strobe Sequencer

This block turns one free-running clock into the control strobes that a byte-wide delay line needs on each sample. Every sample interval it sends one step pulse to an external address counter, upward or downward. It then visits the two halves of the memory in turn. Each visit reads the stored byte for playback and then overwrites that same location with the new input byte.

The clock runs at half-phase resolution. A sample interval is four phases, which is eight clock cycles, numbered slot 0 to slot 7 from the step pulse. The schedule is:

| Slot | Action |
|------|--------|
| 0 | step pulse |
| 1 | read, bank 0 |
| 2 | gap |
| 3 | write, bank 0 |
| 4 | bank 1 selected |
| 5 | read, bank 1 |
| 6 | gap |
| 7 | write, bank 1 |

A reverse request makes the step go downward, so playback and recording both walk backward. A freeze level suppresses the overwrites, so the stored loop is held while playback continues. All outputs are registered. Interval slot k is visible on the outputs after the (k+1)-th rising edge that follows reset release.

Top module: `delay_strobe_seq`

## Requirements
- R1: While rst_n is low at a rising edge, the outputs after that edge are rd_n=1, wr_n=1, bank=0, step_up=0 and step_dn=0, whatever rev_req and freeze are doing.
- R2: After reset release, the first rising edge starts slot 0. Exactly one step pulse occurs per 8-cycle interval, it lasts one cycle, and step_up and step_dn are never high together.
- R3: The step direction is taken from rev_req at the edge that starts slot 0. A high rev_req gives step_dn, a low one gives step_up. A level of rev_req during slots 1 to 7 has no effect on any output.
- R4: bank is 0 in slots 0 to 3 and 1 in slots 4 to 7. It therefore returns to 0 in the same cycle as the step pulse.
- R5: rd_n is low only in slots 1 and 5. wr_n is low only in slots 3 and 7, unless freeze suppresses it.
- R6: A read never starts in the step cycle. The first read of an interval starts in the cycle after the step pulse.
- R7: rd_n and wr_n are never low together, and the cycle after any read cycle has both strobes high.
- R8: If freeze is high at the edge that enters a write slot, wr_n stays high in that slot. rd_n, bank and the step pulses keep their normal pattern.
- R9: bank holds the same value from each read through the write that follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-phase clock (two cycles per phase) |
| rst_n | input | 1 | Synchronous reset, active low |
| rev_req | input | 1 | Reverse request; high selects a downward step |
| freeze | input | 1 | High suppresses write strobes |
| step_up | output | 1 | One-cycle pulse: advance the address counter |
| step_dn | output | 1 | One-cycle pulse: move the address counter back |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bank | output | 1 | Memory half select |

## Verification
Two pairs of events share a cycle. In slot 0 the step pulse coincides with the bank returning to 0. In slot 7 the decision to suppress a write coincides with a change of the freeze level. The bench drives freeze on and off in the half cycle just before each write slot's edge. It also places a one-slot reverse request on and away from the slot-0 edge. It then compares every slot's full output vector against a schedule computed from the slot number and the inputs present at that edge.

// File: rtl/dseq_pkg.sv
// Package: shared strobe bundle and schedule constants for the delay
// strobe sequencer. Assumes an even slot count per interval, with the
// two bank visits laid out identically in each half.
package dseq_pkg;

    typedef struct packed {
        logic step_up;
        logic step_dn;
        logic rd_n;
        logic wr_n;
        logic bank;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{step_up: 1'b0, step_dn: 1'b0,
                                        rd_n: 1'b1, wr_n: 1'b1, bank: 1'b0};

    // Offsets of read and write inside each half-interval bank visit.
    localparam int RD_OFS = 1;
    localparam int WR_OFS = 3;

endpackage

// File: rtl/dseq_slot_ctr.sv
// Module: slot counter. Wraps through SLOTS half-phase slots and exposes
// the slot that the next rising edge enters. Assumes SLOTS >= 2. Reset
// parks it on the last slot, so the first edge after release enters slot 0.
module dseq_slot_ctr #(
    parameter int SLOTS = 8,
    localparam int W = $clog2(SLOTS)
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] slot_next
);
    localparam logic [W-1:0] LAST = W'(SLOTS - 1);

    logic [W-1:0] slot_q;

    // Next-slot computation with wrap at the end of the interval.
    always_comb begin
        slot_next = (slot_q == LAST) ? '0 : slot_q + 1'b1;
    end

    // Slot register; reset parks on the final slot.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= LAST;
        else        slot_q <= slot_next;
    end
endmodule

// File: rtl/dseq_strobe_dec.sv
// Module: strobe decoder. Maps an upcoming slot number, plus the current
// reverse and freeze levels, onto the strobe bundle for that slot. Purely
// combinational. Assumes WR_OFS - RD_OFS >= 2 and WR_OFS < SLOTS/2.
module dseq_strobe_dec
    import dseq_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int W = $clog2(SLOTS),
    localparam int HALF = SLOTS / 2,
    localparam int BANKS = 2
) (
    input  logic [W-1:0] slot,
    input  logic         rev_req,
    input  logic         freeze,
    output strobe_t      strobes
);
    logic [BANKS-1:0] rd_hit;
    logic [BANKS-1:0] wr_hit;

    // One read and one write slot comparator per bank visit.
    for (genvar b = 0; b < BANKS; b++) begin : g_visit
        localparam logic [W-1:0] RD_SLOT = W'(b * HALF + RD_OFS);
        localparam logic [W-1:0] WR_SLOT = W'(b * HALF + WR_OFS);
        assign rd_hit[b] = (slot == RD_SLOT);
        assign wr_hit[b] = (slot == WR_SLOT);
    end

    // Assemble the bundle: step at slot 0, bank from the upper half.
    always_comb begin
        strobes.step_up = (slot == '0) && !rev_req;
        strobes.step_dn = (slot == '0) && rev_req;
        strobes.rd_n    = ~(|rd_hit);
        strobes.wr_n    = ~((|wr_hit) && !freeze);
        strobes.bank    = (slot >= W'(HALF));
    end
endmodule

// File: rtl/delay_strobe_seq.sv
// Module: delay strobe sequencer top. Steps the external address counter
// once per interval, then does a read-then-overwrite in each memory bank.
// All outputs come straight from flops, so there are no decode glitches.
// Assumes inputs are already synchronous to clk.
module delay_strobe_seq
    import dseq_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int W = $clog2(SLOTS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rev_req,
    input  logic freeze,
    output logic step_up,
    output logic step_dn,
    output logic rd_n,
    output logic wr_n,
    output logic bank
);
    logic [W-1:0] slot_next;
    strobe_t      dec_s;
    strobe_t      out_q;

    dseq_slot_ctr #(.SLOTS(SLOTS)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_next (slot_next)
    );

    dseq_strobe_dec #(.SLOTS(SLOTS)) u_dec (
        .slot    (slot_next),
        .rev_req (rev_req),
        .freeze  (freeze),
        .strobes (dec_s)
    );

    // Output register: strobes for the slot being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= STROBE_IDLE;
        else        out_q <= dec_s;
    end

    assign step_up = out_q.step_up;
    assign step_dn = out_q.step_dn;
    assign rd_n    = out_q.rd_n;
    assign wr_n    = out_q.wr_n;
    assign bank    = out_q.bank;
endmodule

// File: rtl/delay_strobe_seq_chk.sv
// Module: protocol checker for the delay strobe sequencer, bound to the top.
module delay_strobe_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic freeze,
    input logic step_up,
    input logic step_dn,
    input logic rd_n,
    input logic wr_n,
    input logic bank
);
    // R2
    step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_dn));

    // R2
    step_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up || step_dn) |=> !(step_up || step_dn));

    // R6
    read_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up || step_dn) |-> rd_n ##1 !rd_n);

    // R4
    step_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up || step_dn) |-> !bank);

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R7
    read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |=> (rd_n && wr_n));

    // R9
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (bank == $past(bank, 2)));

    // R8
    freeze_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(freeze) |-> wr_n);
endmodule

bind delay_strobe_seq delay_strobe_seq_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .freeze  (freeze),
    .step_up (step_up),
    .step_dn (step_dn),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .bank    (bank)
);

// File: tb/test_delay_strobe_seq.sv
// Directed bench for the delay strobe sequencer. Inputs change on falling
// edges; outputs are sampled on falling edges after the edge of interest.
module test_delay_strobe_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rev_req = 1'b0;
    logic freeze = 1'b0;
    logic step_up, step_dn, rd_n, wr_n, bank;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    delay_strobe_seq i_delay_strobe_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rev_req (rev_req),
        .freeze  (freeze),
        .step_up (step_up),
        .step_dn (step_dn),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .bank    (bank)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [4:0] got, input logic [4:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    // Expected {step_up,step_dn,rd_n,wr_n,bank} for slot s.
    function automatic logic [4:0] exp_vec(input int s, input logic r, input logic f);
        logic cu, cd, rd, wr, bk;
        cu = (s == 0) && !r;
        cd = (s == 0) && r;
        rd = !((s == 1) || (s == 5));
        wr = !(((s == 3) || (s == 7)) && !f);
        bk = (s >= 4);
        return {cu, cd, rd, wr, bk};
    endfunction

    function automatic string req_of(input int s, input logic f);
        if (s == 0) return "R3";
        if (s == 4) return "R4";
        if ((s == 3) || (s == 7)) return f ? "R8" : "R5";
        if ((s == 1) || (s == 5)) return "R6";
        return "R7";
    endfunction

    // Runs one interval. Bit s of each mask is the level applied just before
    // the edge that enters slot s. Caller must sit at a falling edge with
    // slot 0 next.
    task automatic run_interval(input logic [7:0] rev_m, input logic [7:0] frz_m,
                                input string name);
        int pulses = 0;
        logic bank_rd_a = 1'b0, bank_rd_b = 1'b0;
        for (int s = 0; s < 8; s++) begin
            logic [4:0] got, exp;
            rev_req = rev_m[s];
            freeze  = frz_m[s];
            @(posedge clk);
            @(negedge clk);
            got = {step_up, step_dn, rd_n, wr_n, bank};
            exp = exp_vec(s, rev_m[0], frz_m[s]);
            check(got == exp, req_of(s, frz_m[s]), $sformatf("%s slot %0d", name, s), got, exp);
            pulses += int'(step_up) + int'(step_dn);
            if (s == 1) bank_rd_a = bank;
            if (s == 5) bank_rd_b = bank;
            if (s == 3) check(bank == bank_rd_a, "R9", {name, " bank A visit"}, 5'(bank), 5'(bank_rd_a));
            if (s == 7) check(bank == bank_rd_b, "R9", {name, " bank B visit"}, 5'(bank), 5'(bank_rd_b));
        end
        check(pulses == 1, "R2", {name, " pulses per interval"}, 5'(pulses), 5'd1);
    endtask

    // R1: outputs idle while reset is held, under toggling inputs.
    task automatic test_reset();
        logic [4:0] got;
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            rev_req = i[0];
            freeze  = i[1];
            @(posedge clk);
            @(negedge clk);
            got = {step_up, step_dn, rd_n, wr_n, bank};
            check(got == 5'b00110, "R1", $sformatf("reset cycle %0d", i), got, 5'b00110);
        end
        rst_n = 1'b1;
    endtask

    task automatic test_forward();
        run_interval(8'h00, 8'h00, "forward 1");
        run_interval(8'h00, 8'h00, "forward 2");
    endtask

    // R3: reverse held through the interval gives a downward step.
    task automatic test_reverse();
        run_interval(8'hFF, 8'h00, "reverse held");
    endtask

    // R3: reverse present only off slot 0 has no effect.
    task automatic test_reverse_late();
        run_interval(8'b1111_1110, 8'h00, "reverse late");
        run_interval(8'h01, 8'h00, "reverse at step only");
    endtask

    // R8: freeze held through the interval, then around each write edge.
    task automatic test_freeze();
        run_interval(8'h00, 8'hFF, "freeze held");
        run_interval(8'h00, 8'b0000_1000, "freeze at write A");
        run_interval(8'h00, 8'b0111_1111, "freeze dropped at write B");
        run_interval(8'hFF, 8'b1000_0000, "freeze write B with reverse");
    endtask

    // R1/R2: reset in mid-interval, then realignment to slot 0.
    task automatic test_mid_reset();
        for (int i = 0; i < 3; i++) @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check({step_up, step_dn, rd_n, wr_n, bank} == 5'b00110, "R1", "mid reset",
              {step_up, step_dn, rd_n, wr_n, bank}, 5'b00110);
        rst_n = 1'b1;
        run_interval(8'h00, 8'h00, "after mid reset");
    endtask

    initial begin
        @(negedge clk);
        test_reset();
        test_forward();
        test_reverse();
        test_reverse_late();
        test_freeze();
        test_mid_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule